// File: doc/BRIEF.md
# Illegal-Condition Reset Detector

This block sits beside the core of a small 16-bit processor and watches three event streams: instruction fetches, working-register traffic (writes and uses of a register as an address pointer), and program-counter reloads. When one of these events describes an illegal condition, the block issues a one-cycle device reset request together with a cause vector. The illegal conditions are:

- a fetched 24-bit word that carries the reserved opcode byte;
- pointer use of a working register that has not been written since the last reset;
- a reload of the program counter into a guarded part of a protected memory segment.

Each protected segment is given as an inclusive address range plus one permitted entry address. A reload anywhere else inside the range is a violation. The check applies in the same way to reloads from calls, jumps, computed jumps, returns and other branches (flow reloads), and to reloads from interrupt or trap vectors (vector reloads). Only the cause bit differs between the two. Because the request resets the device, the block returns its register-tracking state to the reset value when it raises the request. Events that arrive in the cycle the request is high are ignored.

Top module: `illegal_cond_rst_det`

## Requirements
- R1: A fetch (`fetch_vld_i`=1) whose bits [23:16] equal 0x3F raises `rst_req_o` in the next cycle with `cause_o[0]`=1. Any other value in bits [23:16] raises nothing, even if 0x3F appears in lower bytes.
- R2: After any reset, only W15 counts as initialized. A write strobe to register n marks n initialized from the next cycle on. A pointer use of an uninitialized register raises a request with `cause_o[1]`=1. A write and a pointer use of the same register in the same cycle use the state from before the write.
- R3: A pointer use of W15 (index 15) never raises a request.
- R4: A reload whose target lies inside a segment's inclusive [low, high] range and differs from that segment's entry address raises a request. The cause is `cause_o[2]` for a flow reload (`pcl_vec_i`=0) and `cause_o[3]` for a vector reload (`pcl_vec_i`=1).
- R5: A reload to a segment's entry address, or to any address outside every segment range, raises no request. Segment k occupies bits [16k+15:16k] of the segment ports.
- R6: The request is a single-cycle pulse in the cycle after the event. Conditions that occur in the same cycle give one request, and `cause_o` holds the OR of their bits. `cause_o` is zero whenever `rst_req_o` is low.
- R7: Events in the cycle where `rst_req_o` is high are ignored, writes included. After a request, only W15 counts as initialized.
- R8: While `rst_ni` is low, `rst_req_o` and `cause_o` stay zero and the tracking state returns to its reset value. Events are detected again from the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | Fetched instruction word valid |
| fetch_word_i | input | 24 | Fetched instruction word |
| wr_vld_i | input | 1 | Working-register write strobe |
| wr_idx_i | input | 4 | Index of the written register |
| ptr_vld_i | input | 1 | Register used as address pointer |
| ptr_idx_i | input | 4 | Index of the pointer register |
| pcl_vld_i | input | 1 | Program-counter reload event |
| pcl_vec_i | input | 1 | 1 = vector reload, 0 = flow reload |
| pcl_tgt_i | input | 16 | Reload target address |
| seg_lo_i | input | 32 | Per-segment lowest address |
| seg_hi_i | input | 32 | Per-segment highest address |
| seg_entry_i | input | 32 | Per-segment permitted entry address |
| rst_req_o | output | 1 | One-cycle device reset request |
| cause_o | output | 4 | Cause: [0] opcode, [1] uninitialized pointer, [2] flow security, [3] vector security |

## Verification
The opcode check is tried with the reserved byte in the top position and with near misses (neighbouring values, the byte placed lower in the word). This separates a check on the right field from a loose match. Pointer use is tried before any write, after a write, together with a write in the same cycle, and after a request. This separates the initialized mask from a stale or early-updated one. Reload targets are placed at each segment's bounds, one address past them, and on the entry address, for both reload kinds. A combined cycle and events placed in the request cycle show that only one pulse is produced and that the cause bits merge.

// File: rtl/illegal_cond_rst_det.sv
module illegal_cond_rst_det #(
  parameter int INSN_W = 24,
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] BAD_OPC = 8'h3F,
  parameter int NREG = 16,
  parameter int AW = 16,
  parameter int NSEG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_vld_i,
  input  logic [INSN_W-1:0]   fetch_word_i,
  input  logic                wr_vld_i,
  input  logic [$clog2(NREG)-1:0] wr_idx_i,
  input  logic                ptr_vld_i,
  input  logic [$clog2(NREG)-1:0] ptr_idx_i,
  input  logic                pcl_vld_i,
  input  logic                pcl_vec_i,
  input  logic [AW-1:0]       pcl_tgt_i,
  input  logic [NSEG*AW-1:0]  seg_lo_i,
  input  logic [NSEG*AW-1:0]  seg_hi_i,
  input  logic [NSEG*AW-1:0]  seg_entry_i,
  output logic                rst_req_o,
  output logic [3:0]          cause_o
);

  localparam logic [NREG-1:0] RST_MASK = {1'b1, {(NREG-1){1'b0}}};

  logic [NREG-1:0] init_mask;
  logic [NSEG-1:0] seg_bad;
  logic [3:0]      hit;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [AW-1:0] lo, hi, ent;
    assign lo  = seg_lo_i[g*AW +: AW];
    assign hi  = seg_hi_i[g*AW +: AW];
    assign ent = seg_entry_i[g*AW +: AW];
    assign seg_bad[g] = (pcl_tgt_i >= lo) && (pcl_tgt_i <= hi) && (pcl_tgt_i != ent);
  end

  assign hit[0] = fetch_vld_i && (fetch_word_i[INSN_W-1 -: OPC_W] == BAD_OPC);
  assign hit[1] = ptr_vld_i && !init_mask[ptr_idx_i];
  assign hit[2] = pcl_vld_i && !pcl_vec_i && (|seg_bad);
  assign hit[3] = pcl_vld_i &&  pcl_vec_i && (|seg_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      cause_o   <= '0;
      init_mask <= RST_MASK;
    end else if (rst_req_o) begin
      rst_req_o <= 1'b0;
      cause_o   <= '0;
    end else if (|hit) begin
      rst_req_o <= 1'b1;
      cause_o   <= hit;
      init_mask <= RST_MASK;
    end else if (wr_vld_i) begin
      init_mask[wr_idx_i] <= 1'b1;
    end
  end

  assert_opcode_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && fetch_word_i[INSN_W-1 -: OPC_W] == BAD_OPC && !rst_req_o) |=> (rst_req_o && cause_o[0]));

  assert_write_marks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld_i && !rst_req_o && hit == 4'b0) |=> init_mask[$past(wr_idx_i)]);

  assert_w15_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_mask[NREG-1]);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_cause_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o |-> (cause_o == 4'b0));

  assert_req_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cause_o != 4'b0));

  assert_req_cycle_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> $stable(init_mask));

  assert_mask_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (init_mask == RST_MASK));

endmodule

// File: tb/illegal_cond_rst_det_tb_top.sv
`timescale 1ns/1ps
module illegal_cond_rst_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic fv = 0, wv = 0, pv = 0, lv = 0, lvec = 0;
  logic [23:0] fw = '0;
  logic [3:0] wi = '0, pi = '0;
  logic [15:0] lt = '0;
  logic [31:0] slo = {16'h17FF & 16'h1000, 16'h0200};
  logic [31:0] shi = {16'h17FF, 16'h03FF};
  logic [31:0] sen = {16'h1100, 16'h0200};
  logic req;
  logic [3:0] cause;

  illegal_cond_rst_det dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_vld_i(fv), .fetch_word_i(fw),
    .wr_vld_i(wv), .wr_idx_i(wi),
    .ptr_vld_i(pv), .ptr_idx_i(pi),
    .pcl_vld_i(lv), .pcl_vec_i(lvec), .pcl_tgt_i(lt),
    .seg_lo_i(slo), .seg_hi_i(shi), .seg_entry_i(sen),
    .rst_req_o(req), .cause_o(cause));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  logic [15:0] bm = 16'h8000;
  logic breq = 0;

  function automatic bit restricted(input logic [15:0] t);
    return ((t >= 16'h0200 && t <= 16'h03FF && t != 16'h0200) ||
            (t >= 16'h1000 && t <= 16'h17FF && t != 16'h1100));
  endfunction

  task automatic step(input logic f_v, input logic [23:0] f_w,
                      input logic w_v, input logic [3:0] w_i,
                      input logic p_v, input logic [3:0] p_i,
                      input logic l_v, input logic l_vec, input logic [15:0] l_t,
                      input string tag);
    logic [3:0] c;
    logic [4:0] e;
    @(negedge clk);
    fv = f_v; fw = f_w; wv = w_v; wi = w_i; pv = p_v; pi = p_i;
    lv = l_v; lvec = l_vec; lt = l_t;
    c = 4'b0;
    if (f_v && f_w[23:16] == 8'h3F) c[0] = 1'b1;
    if (p_v && !bm[p_i]) c[1] = 1'b1;
    if (l_v && restricted(l_t)) begin
      if (l_vec) c[3] = 1'b1; else c[2] = 1'b1;
    end
    if (breq) begin e = 5'b0; breq = 0; end
    else if (c != 4'b0) begin e = {1'b1, c}; bm = 16'h8000; breq = 1; end
    else begin e = 5'b0; if (w_v) bm[w_i] = 1'b1; end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 24'h0, 0, 4'h0, 0, 4'h0, 0, 0, 16'h0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({req, cause} !== e) begin
        errors++;
        $display("FAIL %s: got req=%0b cause=%04b expected req=%0b cause=%04b",
                 t, req, cause, e[4], e[3:0]);
      end
    end
  end

  task automatic direct(input string tag);
    checks++;
    if (req !== 1'b0 || cause !== 4'b0) begin
      errors++;
      $display("FAIL %s: got req=%0b cause=%04b expected req=0 cause=0000", tag, req, cause);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    direct("R8 reset state");
    rst_n = 1'b1;
    idle("R8 idle after release");
    // R1 opcode checks
    step(1, 24'h3F1234, 0, 0, 0, 0, 0, 0, 0, "R1 reserved opcode");
    idle("R7 request cycle");
    step(1, 24'h3E0000, 0, 0, 0, 0, 0, 0, 0, "R1 near miss 0x3E");
    step(1, 24'h7F0000, 0, 0, 0, 0, 0, 0, 0, "R1 near miss 0x7F");
    step(1, 24'h003F3F, 0, 0, 0, 0, 0, 0, 0, "R1 byte in low field");
    step(0, 24'h3F0000, 0, 0, 0, 0, 0, 0, 0, "R1 not valid");
    // pointer checks
    step(0, 0, 0, 0, 1, 4'd15, 0, 0, 0, "R3 W15 pointer");
    step(0, 0, 0, 0, 1, 4'd3, 0, 0, 0, "R2 uninit pointer");
    idle("R7 request cycle");
    step(0, 0, 1, 4'd3, 1, 4'd3, 0, 0, 0, "R2 write and use same cycle");
    idle("R7 request cycle");
    step(0, 0, 1, 4'd3, 0, 0, 0, 0, 0, "R2 write reg3");
    step(0, 0, 0, 0, 1, 4'd3, 0, 0, 0, "R2 init pointer");
    step(0, 0, 0, 0, 1, 4'd4, 0, 0, 0, "R2 other reg uninit");
    idle("R7 request cycle");
    step(0, 0, 0, 0, 1, 4'd3, 0, 0, 0, "R7 mask cleared by request");
    idle("R7 request cycle");
    // reload checks
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h0250, "R4 flow into boot");
    idle("R7 request cycle");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'h1200, "R4 vector into secure");
    idle("R7 request cycle");
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h0200, "R5 boot entry");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'h1100, "R5 secure entry");
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h0400, "R5 above boot");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'h0FFF, "R5 below secure");
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h1800, "R5 above secure");
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h03FF, "R4 boot high bound");
    idle("R7 request cycle");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'h1000, "R4 secure low bound");
    idle("R7 request cycle");
    // combined
    step(1, 24'h3F0000, 0, 0, 1, 4'd5, 1, 1, 16'h0300, "R6 combined causes");
    step(1, 24'h3F0000, 1, 4'd6, 0, 0, 0, 0, 0, "R7 events in request cycle");
    step(0, 0, 0, 0, 1, 4'd6, 0, 0, 0, "R7 write in request cycle dropped");
    idle("R7 request cycle");
    idle("R6 no repeat");
    // reset in the middle
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    fv = 1; fw = 24'h3F0000; pv = 1; pi = 4'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      direct("R8 held in reset");
    end
    bm = 16'h8000; breq = 0;
    fv = 0; pv = 0;
    rst_n = 1'b1;
    step(1, 24'h3F0000, 0, 0, 0, 0, 0, 0, 0, "R8 armed after release");
    idle("R7 request cycle");
    step(0, 0, 0, 0, 1, 4'd15, 0, 0, 0, "R3 W15 after reset");
    idle("R6 quiet");
    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule